// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is a synthesizable behavioural model of a 1 Kbit serial EEPROM as seen from its pins. A host drives chip select, a shift clock and a serial data line. A static organization input chooses between 128 bytes and 64 sixteen-bit words. The block answers on a serial data output that has its own drive enable, so the enclosing design can build the tri-state pad. All pins are sampled by the system clock. A rising shift-clock edge is detected in the sampled domain.

Each frame opens with a start bit. Two opcode bits and an address follow. When the opcode is 00, the two top address bits select an extended function. The block holds the array in registers. It carries a write-enable latch that is clear after reset. A self-timed program cycle is emulated by a counter that lasts a set number of system clocks. If the host drops chip select long enough and raises it again during that cycle, the block reports busy or ready on the output.

Top module: `serial_eeprom`

## Requirements
- R1: A frame begins only after chip select rises. Zeros sampled before the first 1 are skipped, and that first 1 is the start bit. The start bit is followed by a 2-bit opcode, sent MSB first. Then comes an address, sent MSB first: 7 bits when `wideSel` is 0 (byte mode) and 6 bits when `wideSel` is 1 (word mode). Serial input is sampled on rising shift-clock edges.
- R2: Opcode 10 reads. On the rising edge that carries the last address bit, the output is driven to 0 as a dummy bit. Each of the next 8 rising edges (byte mode) or 16 rising edges (word mode) presents the next data bit, MSB first. The rising edge after the last data bit releases the output. Reading works whatever the state of the write-enable latch.
- R3: The write-enable latch is clear after reset. Opcode 00 with top address bits 11 sets the latch, and opcode 00 with top address bits 00 clears it. While the latch is clear, every programming command leaves the array unchanged and starts no program cycle.
- R4: Opcode 01, followed by the address and then the data MSB first, stores one location. In byte mode, byte address a lives in word a>>1: the upper half when a[0] is 1 and the lower half when a[0] is 0.
- R5: Opcode 11 sets every bit of the addressed location to 1.
- R6: Opcode 00 with top address bits 10 sets every bit of the array to 1. Opcode 00 with top address bits 01, followed by one data item, writes that item to every location. In byte mode, this means both halves of every word.
- R7: A program cycle starts right after the last bit of a programming command is sampled and lasts `PROG_CYCLES` system clocks. Commands sent during the cycle are ignored.
- R8: Status is shown when chip select has been low for at least `CS_LOW_MIN` clocks and then rises during a program cycle. The output is then driven 0 while busy and 1 once ready, until chip select falls. A shorter low pulse, or a rise that comes after the cycle has ended, leaves the output released.
- R9: The output is released one clock after chip select is sampled low.
- R10: After reset, every array bit is 1 and the output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, active high |
| sclkIn | input | 1 | Serial shift clock |
| dataIn | input | 1 | Serial data input |
| wideSel | input | 1 | Organization: 0 selects 128 x 8, 1 selects 64 x 16 |
| serOut | output | 1 | Serial data output value, 0 when released |
| serOutEn | output | 1 | High while the output is driven |

## Verification
The hardest case to reach is status polling around the program cycle. The block must show status only when chip select was dropped long enough and then raised while the counter runs, and must show nothing when it was raised too briefly or too late. The stimulus ends a write frame without the usual long low gap. It gives a two-clock low pulse, then clocks a complete write command into the busy block while chip select stays high. It then waits past the cycle and raises chip select again. After that, a word-mode read shows that the stored value survived the ignored command, and another read checks the byte-lane placement.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPC,
    S_ADDR,
    S_DATA,
    S_READ,
    S_PROG,
    S_WAIT
  } ctrlState_e;

  typedef struct packed {
    logic shiftIn;
    logic latchAddr;
    logic loadRead;
    logic shiftOut;
    logic writeWord;
    logic eraseWord;
    logic writeAll;
    logic eraseAll;
  } dpStrobe_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_DIS  = 2'b00;
  localparam logic [1:0] EXT_WALL = 2'b01;
  localparam logic [1:0] EXT_EALL = 2'b10;
  localparam logic [1:0] EXT_EN   = 2'b11;

endpackage

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic              diBit,
  input  logic              wideMode,
  output logic [WORD_W-1:0] shiftNext,
  output logic              readBit
);

  localparam int WORD_AW = $clog2(WORDS);
  localparam int BYTE_AW = WORD_AW + 1;
  localparam int HALF_W  = WORD_W / 2;

  logic [WORD_W-1:0]  mem [WORDS];
  logic [WORD_W-1:0]  shiftReg;
  logic [WORD_W-1:0]  outShift;
  logic               outBit;
  logic [BYTE_AW-1:0] addrReg;
  logic [BYTE_AW-1:0] nxtAddr;
  logic [WORD_AW-1:0] nxtIdx;
  logic [WORD_AW-1:0] wrIdx;
  logic [WORD_W-1:0]  rdWord;
  logic [HALF_W-1:0]  rdHalf;
  logic [WORD_W-1:0]  loadVal;
  logic [WORD_W-1:0]  fillVal;
  logic [WORD_W-1:0]  wrMask;
  logic [WORD_W-1:0]  erMask;

  function automatic logic [WORD_AW-1:0] wordIdx(input logic [BYTE_AW-1:0] a,
                                                  input logic wide);
    return wide ? a[WORD_AW-1:0] : a[BYTE_AW-1:1];
  endfunction

  assign shiftNext = {shiftReg[WORD_W-2:0], diBit};
  assign nxtAddr   = shiftNext[BYTE_AW-1:0];
  assign nxtIdx    = wordIdx(nxtAddr, wideMode);
  assign wrIdx     = wordIdx(addrReg, wideMode);

  assign rdWord  = mem[nxtIdx];
  assign rdHalf  = nxtAddr[0] ? rdWord[WORD_W-1:HALF_W] : rdWord[HALF_W-1:0];
  assign loadVal = wideMode ? rdWord : {rdHalf, {HALF_W{1'b0}}};
  assign fillVal = wideMode ? shiftNext : {2{shiftNext[HALF_W-1:0]}};

  // byte lanes: lane 0 is the lower half, lane 1 the upper half
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign wrMask[g*HALF_W +: HALF_W] = {HALF_W{wideMode | (addrReg[0] == 1'(g))}};
    assign erMask[g*HALF_W +: HALF_W] = {HALF_W{wideMode | (nxtAddr[0] == 1'(g))}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (st.eraseAll) begin
          mem[i] <= '1;
        end else if (st.eraseWord && nxtIdx == WORD_AW'(i)) begin
          mem[i] <= mem[i] | erMask;
        end else if (st.writeAll) begin
          mem[i] <= fillVal;
        end else if (st.writeWord && wrIdx == WORD_AW'(i)) begin
          mem[i] <= (mem[i] & ~wrMask) | (fillVal & wrMask);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
      outShift <= '0;
      outBit   <= 1'b0;
    end else begin
      if (st.shiftIn)   shiftReg <= shiftNext;
      if (st.latchAddr) addrReg  <= nxtAddr;
      if (st.loadRead) begin
        outShift <= loadVal;
        outBit   <= 1'b0;
      end else if (st.shiftOut) begin
        outBit   <= outShift[WORD_W-1];
        outShift <= {outShift[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign readBit = outBit;

  AST_ONE_PROG_OP: assert property (@(posedge clk) disable iff (!rstN)
    $countones({st.writeWord, st.eraseWord, st.writeAll, st.eraseAll}) <= 1); // R6

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rstN)
    st.eraseWord |=> ((mem[$past(nxtIdx)] & $past(erMask)) == $past(erMask))); // R5

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int WORDS       = 64,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 5000,
  parameter int CS_LOW_MIN  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              sclkIn,
  input  logic              dataIn,
  input  logic              wideSel,
  input  logic [WORD_W-1:0] shiftNext,
  output dpStrobe_t         st,
  output logic              diBit,
  output logic              wideMode,
  output logic              outEn,
  output logic              outStatus,
  output logic              statusVal
);

  localparam int WORD_AW = $clog2(WORDS);
  localparam int BYTE_AW = WORD_AW + 1;
  localparam int HALF_W  = WORD_W / 2;
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int PC_W    = $clog2(PROG_CYCLES + 1);
  localparam int LC_W    = $clog2(CS_LOW_MIN + 1);
  localparam logic [CNT_W-1:0] ALEN_WIDE = CNT_W'(WORD_AW);
  localparam logic [CNT_W-1:0] ALEN_BYTE = CNT_W'(BYTE_AW);
  localparam logic [CNT_W-1:0] DLEN_WIDE = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] DLEN_BYTE = CNT_W'(HALF_W);
  localparam logic [PC_W-1:0]  PROG_LAST = PC_W'(PROG_CYCLES - 1);
  localparam logic [LC_W-1:0]  LOW_MIN   = LC_W'(CS_LOW_MIN);

  logic csQ, csD, sclkQ, sclkD;
  logic sclkRise, csRise;
  ctrlState_e state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext, addrLen, dataLen;
  logic [1:0] opReg, opNext, extTop;
  logic isAll, allNext;
  logic wen, wenNext;
  logic [PC_W-1:0] progCnt;
  logic progStart;
  logic [LC_W-1:0] lowCnt;
  logic statusOn;

  // pin sampling into the system clock domain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ <= 1'b0; csD <= 1'b0; sclkQ <= 1'b0; sclkD <= 1'b0;
      diBit <= 1'b0; wideMode <= 1'b0;
    end else begin
      csQ <= csIn; csD <= csQ; sclkQ <= sclkIn; sclkD <= sclkQ;
      diBit <= dataIn; wideMode <= wideSel;
    end
  end

  assign sclkRise = sclkQ & ~sclkD;
  assign csRise   = csQ & ~csD;
  assign addrLen  = wideMode ? ALEN_WIDE : ALEN_BYTE;
  assign dataLen  = wideMode ? DLEN_WIDE : DLEN_BYTE;
  assign extTop   = wideMode ? shiftNext[WORD_AW-1 -: 2] : shiftNext[BYTE_AW-1 -: 2];

  always_comb begin
    stNext  = state;
    cntNext = bitCnt;
    opNext  = opReg;
    allNext = isAll;
    wenNext = wen;
    st      = '0;
    if (state == S_PROG) begin
      if (progCnt == '0) stNext = S_WAIT;
    end else if (!csQ) begin
      stNext = S_IDLE;
    end else if (sclkRise) begin
      unique case (state)
        S_IDLE: begin
          if (diBit) begin
            stNext  = S_OPC;
            cntNext = '0;
          end
        end
        S_OPC: begin
          opNext = {opReg[0], diBit};
          if (bitCnt == CNT_W'(1)) begin
            stNext  = S_ADDR;
            cntNext = '0;
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        S_ADDR: begin
          st.shiftIn = 1'b1;
          if (bitCnt == addrLen - 1'b1) begin
            cntNext = '0;
            unique case (opReg)
              OP_READ: begin
                st.loadRead = 1'b1;
                stNext      = S_READ;
              end
              OP_ERASE: begin
                st.eraseWord = wen;
                stNext       = wen ? S_PROG : S_WAIT;
              end
              OP_WRITE: begin
                st.latchAddr = 1'b1;
                allNext      = 1'b0;
                stNext       = S_DATA;
              end
              default: begin
                unique case (extTop)
                  EXT_EN: begin
                    wenNext = 1'b1;
                    stNext  = S_WAIT;
                  end
                  EXT_DIS: begin
                    wenNext = 1'b0;
                    stNext  = S_WAIT;
                  end
                  EXT_EALL: begin
                    st.eraseAll = wen;
                    stNext      = wen ? S_PROG : S_WAIT;
                  end
                  default: begin
                    allNext = 1'b1;
                    stNext  = S_DATA;
                  end
                endcase
              end
            endcase
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        S_DATA: begin
          st.shiftIn = 1'b1;
          if (bitCnt == dataLen - 1'b1) begin
            st.writeAll  = wen & isAll;
            st.writeWord = wen & ~isAll;
            stNext       = wen ? S_PROG : S_WAIT;
          end else begin
            cntNext = bitCnt + 1'b1;
          end
        end
        S_READ: begin
          if (bitCnt == dataLen) begin
            stNext = S_WAIT;
          end else begin
            st.shiftOut = 1'b1;
            cntNext     = bitCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
    progStart = (stNext == S_PROG) && (state != S_PROG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      opReg  <= '0;
      isAll  <= 1'b0;
      wen    <= 1'b0;
    end else begin
      state  <= stNext;
      bitCnt <= cntNext;
      opReg  <= opNext;
      isAll  <= allNext;
      wen    <= wenNext;
    end
  end

  // self-timed program cycle emulation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      progCnt <= '0;
    end else if (progStart) begin
      progCnt <= PROG_LAST;
    end else if (state == S_PROG && progCnt != '0) begin
      progCnt <= progCnt - 1'b1;
    end
  end

  // chip-select low time and status display
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt   <= '0;
      statusOn <= 1'b0;
    end else begin
      if (csQ) lowCnt <= '0;
      else if (lowCnt < LOW_MIN) lowCnt <= lowCnt + 1'b1;
      if (!csQ) statusOn <= 1'b0;
      else if (csRise && state == S_PROG && lowCnt >= LOW_MIN) statusOn <= 1'b1;
    end
  end

  assign outEn     = csQ & ((state == S_READ) | statusOn);
  assign outStatus = statusOn;
  assign statusVal = (state != S_PROG);

  AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_PROG && stNext == S_PROG) |-> wen); // R3

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROG && progCnt != '0) |=> state == S_PROG); // R7

  AST_STATUS_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !csQ |=> !statusOn); // R8

  AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    state == S_READ |-> bitCnt <= dataLen); // R2

  AST_RELEASE_CS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> !outEn); // R9

endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
  import eeprom_pkg::*;
#(
  parameter int WORDS       = 64,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 5000,
  parameter int CS_LOW_MIN  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sclkIn,
  input  logic dataIn,
  input  logic wideSel,
  output logic serOut,
  output logic serOutEn
);

  dpStrobe_t         strobes;
  logic [WORD_W-1:0] shiftNext;
  logic              diBit, wideMode, outEn, outStatus, statusVal, readBit;

  eeprom_ctrl #(
    .WORDS(WORDS), .WORD_W(WORD_W),
    .PROG_CYCLES(PROG_CYCLES), .CS_LOW_MIN(CS_LOW_MIN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .dataIn(dataIn),
    .wideSel(wideSel), .shiftNext(shiftNext), .st(strobes), .diBit(diBit),
    .wideMode(wideMode), .outEn(outEn), .outStatus(outStatus), .statusVal(statusVal)
  );

  eeprom_datapath #(
    .WORDS(WORDS), .WORD_W(WORD_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .diBit(diBit), .wideMode(wideMode),
    .shiftNext(shiftNext), .readBit(readBit)
  );

  assign serOutEn = outEn;
  assign serOut   = outEn & (outStatus ? statusVal : readBit);

endmodule

// File: tb/test_serial_eeprom.sv
module test_serial_eeprom;

  localparam int PROG  = 300;
  localparam int LOWMN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs = 1'b0, sclk = 1'b0, di = 1'b0, wide = 1'b1;
  logic serOut, serOutEn;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [128];
  bit wenModel = 0;

  always #5 clk = ~clk;

  serial_eeprom #(.PROG_CYCLES(PROG), .CS_LOW_MIN(LOWMN)) i_serial_eeprom (
    .clk(clk), .rstN(rstN), .csIn(cs), .sclkIn(sclk), .dataIn(di),
    .wideSel(wide), .serOut(serOut), .serOutEn(serOutEn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // R9: every clock, a chip select held low means a released output
  always @(posedge clk) begin
    #1;
    if (rstN && !cs) chk(serOutEn === 1'b0, "R9", "release while deselected", serOutEn, 0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not end", 0, 1);
    summary();
  end

  task automatic sk(input logic b);
    @(negedge clk); sclk = 1'b0; di = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic startFrame(input int lowLen);
    @(negedge clk); cs = 1'b0; sclk = 1'b0;
    repeat (lowLen) @(negedge clk);
    cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic endFrame();
    @(negedge clk); cs = 1'b0; sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendHead(input logic [1:0] op, input int addr);
    int alen = wide ? 6 : 7;
    sk(1'b1); sk(op[1]); sk(op[0]);
    for (int i = alen - 1; i >= 0; i--) sk(addr[i]);
  endtask

  task automatic sendData(input int d);
    int dlen = wide ? 16 : 8;
    for (int i = dlen - 1; i >= 0; i--) sk(d[i]);
  endtask

  function automatic int expRead(input int a);
    if (wide) return {model[2*a+1], model[2*a]};
    return int'(model[a]);
  endfunction

  task automatic doRead(input int addr, input int leadZeros, input string req);
    int e = expRead(addr);
    int dlen = wide ? 16 : 8;
    int got = 0;
    bit allDriven = 1;
    startFrame(8);
    for (int i = 0; i < leadZeros; i++) sk(1'b0);
    sendHead(2'b10, addr);
    chk(serOutEn === 1'b1 && serOut === 1'b0, "R2", "dummy bit", {serOutEn, serOut}, 2);
    for (int i = dlen - 1; i >= 0; i--) begin
      sk(1'b0);
      if (serOutEn !== 1'b1) allDriven = 0;
      got = (got << 1) | int'(serOut);
    end
    chk(allDriven && got == e, req, "read data", got, e);
    sk(1'b0);
    chk(serOutEn === 1'b0, "R2", "release after last bit", serOutEn, 0);
    endFrame();
  endtask

  task automatic pollReady(input string req);
    @(negedge clk); cs = 1'b0;
    repeat (8) @(negedge clk);
    cs = 1'b1;
    repeat (5) @(negedge clk);
    chk(serOutEn === 1'b1 && serOut === 1'b0, "R8", "busy status", {serOutEn, serOut}, 2);
    repeat (PROG - 60) @(negedge clk);
    chk(serOutEn === 1'b1 && serOut === 1'b0, "R7", "still busy near end", {serOutEn, serOut}, 2);
    repeat (80) @(negedge clk);
    chk(serOutEn === 1'b1 && serOut === 1'b1, req, "ready status", {serOutEn, serOut}, 3);
    endFrame();
  endtask

  task automatic modelWrite(input int a, input int d);
    if (!wenModel) return;
    if (wide) begin model[2*a] = d[7:0]; model[2*a+1] = d[15:8]; end
    else model[a] = d[7:0];
  endtask

  task automatic doWrite(input int addr, input int d, input bit poll);
    startFrame(8);
    sendHead(2'b01, addr);
    sendData(d);
    modelWrite(addr, d);
    endFrame();
    if (poll) pollReady("R4");
  endtask

  task automatic doExt(input logic [1:0] top);
    int alen = wide ? 6 : 7;
    startFrame(8);
    sendHead(2'b00, int'(top) << (alen - 2));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(serOutEn === 1'b0, "R10", "released after reset", serOutEn, 0);

    // word mode, erased contents after reset
    wide = 1'b1;
    repeat (3) @(negedge clk);
    doRead(5, 0, "R10");

    // programming refused while latch clear after reset
    doWrite(5, 16'h1234, 0);
    startFrame(8);
    repeat (4) @(negedge clk);
    chk(serOutEn === 1'b0, "R3", "no program cycle when disabled", serOutEn, 0);
    endFrame();
    doRead(5, 0, "R3");

    // enable, write, poll
    doExt(2'b11); endFrame(); wenModel = 1;
    doWrite(5, 16'hA5C3, 1);
    doRead(5, 2, "R1");
    doRead(5, 0, "R4");

    // short low pulse gives no status, commands during busy ignored
    startFrame(8);
    sendHead(2'b01, 9);
    sendData(16'h0F0F);
    modelWrite(9, 16'h0F0F);
    @(negedge clk); cs = 1'b0; sclk = 1'b0;
    repeat (2) @(negedge clk);
    cs = 1'b1;
    repeat (5) @(negedge clk);
    chk(serOutEn === 1'b0, "R8", "short low pulse shows nothing", serOutEn, 0);
    sendHead(2'b01, 9);
    sendData(16'h1111);
    repeat (150) @(negedge clk);
    startFrame(8);
    repeat (5) @(negedge clk);
    chk(serOutEn === 1'b0, "R8", "raise after cycle shows nothing", serOutEn, 0);
    endFrame();
    doRead(9, 0, "R7");

    // erase one word
    startFrame(8); sendHead(2'b11, 5); endFrame();
    model[10] = 8'hFF; model[11] = 8'hFF;
    pollReady("R5");
    doRead(5, 0, "R5");

    // byte mode write into upper lane of word 9
    wide = 1'b0;
    repeat (3) @(negedge clk);
    doWrite(7'h13, 8'h7E, 1);
    doRead(7'h13, 0, "R4");
    doRead(7'h12, 0, "R4");
    wide = 1'b1;
    repeat (3) @(negedge clk);
    doRead(9, 0, "R4");

    // fill whole array in byte mode
    wide = 1'b0;
    repeat (3) @(negedge clk);
    doExt(2'b01); sendData(8'h3C); endFrame();
    for (int i = 0; i < 128; i++) model[i] = 8'h3C;
    pollReady("R6");
    doRead(7'h7F, 0, "R6");
    wide = 1'b1;
    repeat (3) @(negedge clk);
    doRead(0, 0, "R6");

    // erase whole array
    doExt(2'b10); endFrame();
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    pollReady("R6");
    doRead(63, 0, "R6");

    // disable, then whole-array write must be refused
    doExt(2'b00); endFrame(); wenModel = 0;
    doExt(2'b01); sendData(16'h0000); endFrame();
    startFrame(8);
    repeat (4) @(negedge clk);
    chk(serOutEn === 1'b0, "R3", "no cycle after disable", serOutEn, 0);
    endFrame();
    doRead(10, 0, "R3");
    doRead(10, 0, "R2");

    summary();
  end

endmodule